// File: doc/BRIEF.md
# Serial Sequential-Access Bit Memory

This block is a one-bit-wide storage array with no address bus. An internal counter is the only way to reach a location. A host selects the block with an active-low select and picks write or read with a direction level. It then walks the array one location at a time with an increment strobe. A separate address strobe, given while the data input is low, rewinds the counter to location zero. The bidirectional data pin is split into a data input, a data output and an output enable.

Both strobes are asynchronous to the system clock. They pass through a synchronizer, and only their rising edges are acted on. An end flag marks the last location. During writes the flag latches high. During reads it gives a single-cycle pulse. While the block is deselected, the end flag repeats the direction level, so several blocks can be chained by their end and select signals. Reads stay blocked after reset until one write sequence has completed.

Top module: `ssb_mem`

## Requirements
- R1: While `cs_n` is 1, `dout_oe` is 0 and `eop` equals `wr_dir`.
- R2: A rising edge of `addr_strobe` while selected and `din` = 0 sets the counter to location 0. A rising edge with `din` = 1 leaves the counter unchanged.
- R3: While selected with `wr_dir` = 1, a rising edge of `inc_clk` stores `din` at the current location and then advances the counter by one.
- R4: While selected with `wr_dir` = 0 and reads enabled, `dout_oe` is 1 and `dout` shows the bit stored at the current location.
- R5: After reset, `dout_oe` stays 0 in read mode until reads are enabled. The counter still advances on `inc_clk` edges while reads are locked.
- R6: Reads become enabled, and stay enabled until reset, in either of two cases. The first is an address strobe that ends a write sequence (one or more write increments since the previous strobe). The second is a write increment that moves the counter onto the final location.
- R7: In write mode, `eop` goes to 1 when the counter reaches location DEPTH-1 and holds there. The next address strobe, with either `din` value, returns it to 0.
- R8: In read mode, `eop` is 1 for exactly one system clock cycle when the counter moves onto location DEPTH-1, and is 0 otherwise.
- R9: At location DEPTH-1, further increments keep the counter there. It never wraps.
- R10: When an address strobe and an increment are detected in the same cycle, the strobe is acted on and the increment is dropped: nothing is stored and the counter does not advance.
- R11: After reset, the counter is 0, reads are locked and both end indications are cleared.
- R12: While `cs_n` is 1, address strobes and increments change neither the counter nor the stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select |
| wr_dir | input | 1 | Direction: 1 write, 0 read |
| addr_strobe | input | 1 | Asynchronous start-address strobe |
| inc_clk | input | 1 | Asynchronous counter increment strobe |
| din | input | 1 | Data input half of the bidirectional bit |
| dout | output | 1 | Data output half of the bidirectional bit |
| dout_oe | output | 1 | Output enable for `dout` |
| eop | output | 1 | End-of-page flag, or a copy of `wr_dir` when deselected |

## Verification
Two functions can land in the same system cycle: the counter rewind caused by an address strobe and the store-and-advance caused by an increment. The bench raises both strobes on the same clock edge, so their synchronized edges are detected together, in both read and write mode. It then judges the result at the ports. The output bit must match location 0 and not the location the increment would have reached. The location the write increment would have overwritten is read back later and must still hold its old value.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    typedef struct packed {
        logic strobe;
        logic step;
    } evt_t;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/ssb_edge_det.sv
module ssb_edge_det #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] async_in,
    output logic [LANES-1:0] rise
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES:0] shreg;
        always_ff @(posedge clk) begin
            if (rst) begin
                shreg <= '0;
            end else begin
                shreg <= {shreg[STAGES-1:0], async_in[g]};
            end
        end
        assign rise[g] = shreg[STAGES-1] & ~shreg[STAGES];
    end

endmodule

// File: rtl/ssb_addr_seq.sv
module ssb_addr_seq
    import ssb_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned AW    = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  dir_e          dir,
    input  logic          din,
    input  evt_t          ev,
    output logic [AW-1:0] addr_q,
    output logic          rd_en_q,
    output logic          hold_q,
    output logic          pulse_q,
    output logic          store
);

    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
    localparam logic [AW-1:0] PRELAST = AW'(DEPTH - 2);

    logic strb;
    logic step;
    logic at_last;
    logic to_last;
    logic wr_seq_q;

    assign strb    = sel & ev.strobe;
    assign step    = sel & ev.step & ~ev.strobe;
    assign at_last = (addr_q == LAST);
    assign to_last = (addr_q == PRELAST);
    assign store   = step & (dir == DIR_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            rd_en_q  <= 1'b0;
            hold_q   <= 1'b0;
            pulse_q  <= 1'b0;
            wr_seq_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (strb) begin
                if (!din) begin
                    addr_q <= '0;
                end
                hold_q   <= 1'b0;
                wr_seq_q <= 1'b0;
                if (wr_seq_q) begin
                    rd_en_q <= 1'b1;
                end
            end else if (step) begin
                if (!at_last) begin
                    addr_q <= addr_q + 1'b1;
                end
                if (dir == DIR_WRITE) begin
                    wr_seq_q <= 1'b1;
                    if (to_last) begin
                        hold_q  <= 1'b1;
                        rd_en_q <= 1'b1;
                    end
                end else if (to_last) begin
                    pulse_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ssb_bit_array.sv
module ssb_bit_array #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          wbit,
    output logic          rbit
);

    logic mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wbit;
        end
    end

    assign rbit = mem[addr];

endmodule

// File: rtl/ssb_mem.sv
module ssb_mem
    import ssb_pkg::*;
#(
    parameter int unsigned DEPTH       = 2048,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_dir,
    input  logic addr_strobe,
    input  logic inc_clk,
    input  logic din,
    output logic dout,
    output logic dout_oe,
    output logic eop
);

    localparam int unsigned AW = addr_bits(DEPTH);

    logic [1:0]    rise;
    evt_t          ev;
    dir_e          dir;
    logic          sel;
    logic [AW-1:0] addr_q;
    logic          rd_en_q;
    logic          hold_q;
    logic          pulse_q;
    logic          store;
    logic          rbit;

    assign sel = ~cs_n;
    assign dir = dir_e'(wr_dir);

    ssb_edge_det #(
        .LANES  (2),
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst      (rst),
        .async_in ({addr_strobe, inc_clk}),
        .rise     (rise)
    );

    assign ev = '{strobe: rise[1], step: rise[0]};

    ssb_addr_seq #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .dir     (dir),
        .din     (din),
        .ev      (ev),
        .addr_q  (addr_q),
        .rd_en_q (rd_en_q),
        .hold_q  (hold_q),
        .pulse_q (pulse_q),
        .store   (store)
    );

    ssb_bit_array #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_array (
        .clk  (clk),
        .we   (store),
        .addr (addr_q),
        .wbit (din),
        .rbit (rbit)
    );

    always_comb begin
        dout_oe = sel & (dir == DIR_READ) & rd_en_q;
        dout    = dout_oe ? rbit : 1'b0;
        if (!sel) begin
            eop = wr_dir;
        end else if (dir == DIR_WRITE) begin
            eop = hold_q;
        end else begin
            eop = pulse_q;
        end
    end

endmodule

// File: rtl/ssb_mem_chk.sv
module ssb_mem_chk #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned AW    = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          wr_dir,
    input logic          din,
    input logic          dout_oe,
    input logic          eop,
    input logic [AW-1:0] addr_q,
    input logic          rd_en_q,
    input logic          hold_q,
    input logic          pulse_q,
    input logic          strb_evt,
    input logic          step_evt
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    AST_DESEL_OE: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !dout_oe); // R1
    AST_DESEL_EOP: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (eop == wr_dir)); // R1
    AST_STROBE_REWIND: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && strb_evt && !din) |=> (addr_q == '0)); // R2
    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && step_evt && !strb_evt && addr_q != LAST)
            |=> (addr_q == AW'($past(addr_q) + 1))); // R3
    AST_LOCKED_NO_OE: assert property (@(posedge clk) disable iff (rst)
        !rd_en_q |-> !dout_oe); // R5
    AST_RDEN_STICKY: assert property (@(posedge clk) disable iff (rst)
        rd_en_q |=> rd_en_q); // R6
    AST_WEOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !(strb_evt && !cs_n)) |=> hold_q); // R7
    AST_REOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q); // R8
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (addr_q == LAST && !(strb_evt && !cs_n && !din)) |=> (addr_q == LAST)); // R9
    AST_STROBE_WINS: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && strb_evt && step_evt && din) |=> $stable(addr_q)); // R10
    AST_DESEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(addr_q)); // R12

endmodule

bind ssb_mem ssb_mem_chk #(
    .DEPTH (DEPTH),
    .AW    (AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .wr_dir   (wr_dir),
    .din      (din),
    .dout_oe  (dout_oe),
    .eop      (eop),
    .addr_q   (addr_q),
    .rd_en_q  (rd_en_q),
    .hold_q   (hold_q),
    .pulse_q  (pulse_q),
    .strb_evt (rise[1]),
    .step_evt (rise[0])
);

// File: tb/tb_ssb_mem.sv
module tb_ssb_mem;

    localparam int unsigned DEPTH = 16;
    localparam logic [15:0] PAT_A = 16'b1010_0010_0011_1000;
    localparam logic [15:0] PAT_B = ~PAT_A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic wr_dir = 1'b0;
    logic addr_strobe = 1'b0;
    logic inc_clk = 1'b0;
    logic din = 1'b0;
    logic dout;
    logic dout_oe;
    logic eop;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ssb_mem #(.DEPTH(DEPTH)) dut (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .wr_dir      (wr_dir),
        .addr_strobe (addr_strobe),
        .inc_clk     (inc_clk),
        .din         (din),
        .dout        (dout),
        .dout_oe     (dout_oe),
        .eop         (eop)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic strobe(input logic d);
        @(negedge clk);
        din = d;
        addr_strobe = 1'b1;
        repeat (3) @(negedge clk);
        addr_strobe = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic step(input logic d, output int pulses);
        pulses = 0;
        @(negedge clk);
        din = d;
        inc_clk = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k == 2) inc_clk = 1'b0;
            if (eop) pulses++;
        end
    endtask

    task automatic both(input logic d);
        @(negedge clk);
        din = d;
        addr_strobe = 1'b1;
        inc_clk = 1'b1;
        repeat (3) @(negedge clk);
        addr_strobe = 1'b0;
        inc_clk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic write_pass(input logic [15:0] pat);
        int p;
        wr_dir = 1'b1;
        strobe(1'b0);
        chk("R7", "eop cleared by strobe", eop, 1'b0);
        for (int i = 0; i < DEPTH + 2; i++) begin
            step(pat[(i < DEPTH) ? i : DEPTH - 1], p);
            chk("R7", "write eop level", eop, (i >= DEPTH - 2));
        end
        strobe(1'b0);
        chk("R7", "eop cleared after write pass", eop, 1'b0);
    endtask

    task automatic read_pass(input logic [15:0] pat);
        int p;
        wr_dir = 1'b0;
        strobe(1'b0);
        for (int i = 0; i < DEPTH + 2; i++) begin
            chk("R4", "read oe", dout_oe, 1'b1);
            chk("R4", "read bit", dout, pat[(i < DEPTH) ? i : DEPTH - 1]);
            step(1'b0, p);
            chk("R8", "read eop pulse count", 1'(p), (i == DEPTH - 2));
            if (p > 1) chk("R8", "pulse longer than one cycle", 1'b1, 1'b0);
        end
        chk("R9", "no wrap after last", dout, pat[DEPTH-1]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int p;
        do_reset();
        cs_n = 1'b0;
        wr_dir = 1'b1;
        #1;
        chk("R11", "write eop after reset", eop, 1'b0);
        wr_dir = 1'b0;
        #1;
        chk("R11", "read oe after reset", dout_oe, 1'b0);
        chk("R11", "read eop after reset", eop, 1'b0);

        cs_n = 1'b1;
        wr_dir = 1'b1;
        #1;
        chk("R1", "eop mirrors 1", eop, 1'b1);
        chk("R1", "oe off deselected", dout_oe, 1'b0);
        wr_dir = 1'b0;
        #1;
        chk("R1", "eop mirrors 0", eop, 1'b0);
        cs_n = 1'b0;

        // R3 R7 R9 R6: full write sweep, reaching the last location enables reads
        write_pass(PAT_A);
        read_pass(PAT_A);

        // R12: deselected strobes/increments leave the counter at the last location
        cs_n = 1'b1;
        strobe(1'b0);
        step(1'b0, p);
        cs_n = 1'b0;
        wr_dir = 1'b0;
        #1;
        chk("R12", "counter frozen while deselected", dout, PAT_A[DEPTH-1]);

        // R2: a strobe with din high keeps the counter
        strobe(1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, p);
        strobe(1'b1);
        chk("R2", "strobe din=1 keeps counter", dout, PAT_A[3]);
        strobe(1'b0);
        chk("R2", "strobe din=0 rewinds", dout, PAT_A[0]);

        // R10 in read mode: at location 3 both strobes together
        for (int i = 0; i < 3; i++) step(1'b0, p);
        both(1'b0);
        chk("R10", "read: strobe wins loc0", dout, PAT_A[0]);
        step(1'b0, p);
        chk("R10", "read: next is loc1", dout, PAT_A[1]);

        // R10 in write mode: at location 5, din=0, nothing stored
        wr_dir = 1'b1;
        strobe(1'b0);
        for (int i = 0; i < 5; i++) step(PAT_A[i], p);
        both(1'b0);
        wr_dir = 1'b0;
        #1;
        chk("R10", "write: counter rewound", dout, PAT_A[0]);
        for (int i = 0; i < 5; i++) step(1'b0, p);
        chk("R10", "write: loc5 untouched", dout, PAT_A[5]);

        // R5 R6: second reset, locked reads still advance the counter
        do_reset();
        cs_n = 1'b0;
        wr_dir = 1'b0;
        strobe(1'b0);
        for (int i = 0; i < 2; i++) begin
            step(1'b0, p);
            chk("R5", "locked read oe", dout_oe, 1'b0);
        end
        wr_dir = 1'b1;
        step(PAT_B[2], p);
        step(PAT_B[3], p);
        wr_dir = 1'b0;
        #1;
        chk("R6", "unfinished write keeps lock", dout_oe, 1'b0);
        strobe(1'b0);
        chk("R6", "strobe completes write, oe on", dout_oe, 1'b1);
        chk("R5", "loc0 unchanged", dout, PAT_A[0]);
        step(1'b0, p);
        chk("R5", "loc1 unchanged", dout, PAT_A[1]);
        step(1'b0, p);
        chk("R5", "loc2 written after locked advance", dout, PAT_B[2]);
        step(1'b0, p);
        chk("R3", "loc3 written", dout, PAT_B[3]);

        // second full sweep with the inverted pattern
        write_pass(PAT_B);
        read_pass(PAT_B);
        chk("R6", "read enable persists", dout_oe, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule